// File: doc/BRIEF.md
# Radix-2 Montgomery Multiplier with Precomputed Addend Select

This block forms the Montgomery product A·B·2^(−n) mod P for an odd n-bit modulus P and residues A and B that are both smaller than P. A single start pulse captures the three operands. In the next cycle the block forms the sum B+P and keeps it in a register. It then scans A one bit per cycle, beginning at the least significant bit. In each of these cycles it adds exactly one candidate value to the running value T and halves the sum.

The candidate is one of 0, B, P or the stored B+P. A three-input table picks it from the low bit of T, the current bit of A and the low bit of B. Each iteration therefore needs one adder pass and no second addition. The running value stays below 2P, so after n iterations a single conditional subtraction of P gives the reduced result. That result is presented together with a one-cycle done pulse.

Conversion into and out of the residue domain belongs to the caller. So does any loop over several products, such as exponentiation.

Top module: `mont_mul_r2`

## Requirements
- R1: When done is high, result equals A·B·2^(−WIDTH) mod P for the operands captured at the accepted start, and result is smaller than P.
- R2: done is high for exactly one cycle, and it rises WIDTH+2 clock edges after the edge that samples an accepted start (one precompute edge, WIDTH iteration edges and one final edge).
- R3: busy is high from the edge after an accepted start until the edge that raises done. A start while busy is high is ignored and does not change the operands in flight.
- R4: result changes only together with a done pulse and otherwise holds its value.
- R5: After reset, busy and done are low and result is zero.
- R6: The largest modulus, P = 2^WIDTH − 1, and zero operands give the correct reduced value (zero when either operand is zero).
- R7: While busy, the running value stays below 2P, so one subtraction of P at the end is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the operands when the block is idle |
| op_a | input | WIDTH | Multiplier operand, smaller than modulus |
| op_b | input | WIDTH | Multiplicand operand, smaller than modulus |
| modulus | input | WIDTH | Odd modulus P |
| busy | output | 1 | A product is being computed |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | WIDTH | Reduced Montgomery product |

## Verification
The assertions assume that every accepted start carries an odd modulus of at least 3 and operands strictly below it. The bound on the running value and the check that result is below P rest on that assumption. The stimulus draws the modulus with its low bit forced to one and a floor of 3, and it draws A and B modulo that value. The directed cases stay inside the same limits, including the all-ones modulus and zero operands.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ITER = 2'd2,
    ST_FIN  = 2'd3
  } mm_state_e;
endpackage

// File: rtl/mm_addend_sel.sv
module mm_addend_sel #(
  parameter int WIDTH = 16,
  localparam int TW = WIDTH + 2
) (
  input  logic             t_lsb,
  input  logic             a_bit,
  input  logic             b_lsb,
  input  logic [WIDTH-1:0] b_val,
  input  logic [WIDTH-1:0] p_val,
  input  logic [TW-1:0]    bp_val,
  output logic [TW-1:0]    addend
);
  always_comb begin
    unique case ({t_lsb, a_bit, b_lsb})
      3'b000, 3'b001: addend = '0;
      3'b010, 3'b111: addend = {2'b00, b_val};
      3'b011, 3'b110: addend = bp_val;
      default:        addend = {2'b00, p_val};
    endcase
  end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int WIDTH = 16,
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output mm_pkg::mm_state_e    state_o
);
  import mm_pkg::*;

  mm_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PRE;
      ST_PRE: begin
        state_d = ST_ITER;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_ITER: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(WIDTH - 1)) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2 #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] modulus,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  import mm_pkg::*;
  localparam int TW = WIDTH + 2;

  mm_state_e        state;
  logic [WIDTH-1:0] a_q, b_q, p_q;
  logic [TW-1:0]    bp_q, t_q, t_d, addend, sum;
  logic [WIDTH-1:0] res_q, res_d;
  logic             done_q;
  logic             ld_en, bp_en, t_en, res_en;

  mm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state_o (state)
  );

  mm_addend_sel #(.WIDTH(WIDTH)) u_sel (
    .t_lsb  (t_q[0]),
    .a_bit  (a_q[0]),
    .b_lsb  (b_q[0]),
    .b_val  (b_q),
    .p_val  (p_q),
    .bp_val (bp_q),
    .addend (addend)
  );

  assign ld_en  = (state == ST_IDLE) && start;
  assign bp_en  = (state == ST_PRE);
  assign t_en   = (state == ST_ITER) || ld_en;
  assign res_en = (state == ST_FIN);

  assign sum = t_q + addend;

  always_comb begin
    t_d = ld_en ? '0 : {1'b0, sum[TW-1:1]};
    if (t_q >= {2'b00, p_q}) res_d = WIDTH'(t_q - {2'b00, p_q});
    else                     res_d = t_q[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      bp_q   <= '0;
      t_q    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ld_en) begin
        a_q <= op_a;
        b_q <= op_b;
        p_q <= modulus;
      end else if (state == ST_ITER) begin
        a_q <= {1'b0, a_q[WIDTH-1:1]};
      end
      if (bp_en)  bp_q  <= {2'b00, b_q} + {2'b00, p_q};
      if (t_en)   t_q   <= t_d;
      if (res_en) res_q <= res_d;
      done_q <= res_en;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] p_q,
  input logic [WIDTH+1:0] t_q
);
  assert_result_reduced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < p_q));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));

  assert_t_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (t_q < {1'b0, p_q, 1'b0}));
endmodule

bind mont_mul_r2 mm_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .p_q    (p_q),
  .t_q    (t_q)
);

// File: tb/mont_mul_r2_test.sv
module mont_mul_r2_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  mont_mul_r2 #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  function automatic longint mont_ref(longint a, longint b, longint p);
    longint v = (a * b) % p;
    for (int i = 0; i < W; i++) begin
      if (v[0]) v = v + p;
      v = v / 2;
    end
    return v % p;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(longint a, longint b, longint p, bit interfere);
    int cyc = 0;
    longint exp = mont_ref(a, b, p);
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); modulus = W'(p); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", busy, 1);
    if (interfere) begin
      @(posedge clk); @(negedge clk); cyc++;
      op_a = ~op_a; op_b = 16'h0001; modulus = 16'h0003; start = 1'b1;
      @(posedge clk); @(negedge clk); cyc++;
      start = 1'b0;
    end
    while (!done && cyc < 200) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
    check("R2 latency", cyc, W + 2);
    check("R1 product", result, exp);
    check("R3 idle at done", busy, 0);
    // result*2^W mod P must equal A*B mod P
    check("R1 congruence", ((longint'(result) << W) % p), (a * b) % p);
    @(posedge clk); @(negedge clk);
    check("R2 single pulse", done, 0);
    @(posedge clk); @(negedge clk);
    check("R4 result held", result, exp);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    #3;
    check("R5 busy at reset", busy, 0);
    check("R5 done at reset", done, 0);
    check("R5 result at reset", result, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R6 corners
    run_one(65534, 65533, 65535, 0);
    run_one(0, 12345, 65535, 0);
    run_one(777, 0, 40001, 0);
    run_one(1, 1, 3, 0);
    run_one(2, 2, 3, 0);
    // R3 ignored start in flight
    run_one(4242, 31337, 50021, 1);
    for (int k = 0; k < 60; k++) begin
      longint p = longint'($urandom & 32'hFFFF) | 1;
      if (p < 3) p = 3;
      run_one(longint'($urandom) % p, longint'($urandom) % p, p, (k % 7) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule